// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Port Controller

This block is the digital side of a two-channel successive-approximation converter as a host sees it over a three-wire serial port. A host lowers an active-low select, may clock in any number of zeros, then sends a one as the start marker. Three configuration bits follow: input mode, channel/polarity, and whether a least-significant-first repeat is wanted. The block opens a sample window, makes one successive-approximation decision per serial clock from an external comparator, and shifts a low null bit and then the result out on a data line that is otherwise released.

The serial lines are oversampled by a fast system clock and edge-detected, so the whole block runs in one clock domain. The comparator is external. The block presents the current trial code and the latched input routing. For each trial it reads back one bit: is the routed input at or above the trial code?

Top module: `adc_serial_dev`

## Requirements
- R1: While select is low, serial clock rises with data-in low before the start marker are ignored; the first rise with data-in high is the start marker.
- R2: The three rises after the start marker latch, in order, the mode bit (1 = single-ended), the channel/polarity bit and the repeat bit; `pos_ch` equals the channel/polarity bit and `neg_is_gnd` equals the mode bit (in differential mode the other channel is the negative input).
- R3: `sample_active` goes high at the second rise after the start marker and low at the fall of the third clock after it, and is low at all other times.
- R4: `dout_en` stays low until the fall of the repeat-bit clock; at that fall it goes high and `dout` carries a 0 null bit.
- R5: The next 12 falls drive result bits from bit 11 down to bit 0; before each fall `trial_code` holds the decided upper bits, a 1 in the bit under test and zeros below it, and a 1 on `cmp_in` at that fall keeps the bit.
- R6: `conv_done` pulses high for exactly one system clock once bit 0 is decided, once per frame.
- R7: With the repeat bit at 1, the falls after bit 0 drive bits 1 through 11, and every later fall drives 0.
- R8: With the repeat bit at 0, every fall after bit 0 drives 0.
- R9: Select going high at any point releases `dout` (`dout_en` low), clears `sample_active` and returns to hunting for a start marker on the next low select.
- R10: If select is low when reset ends, no start marker is accepted until select has gone high and then low again.
- R11: The result is straight binary, from 000h for inputs at or below zero to FFFh for full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock oversampling the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| cmp_in | input | 1 | Comparator decision: routed input is at or above `trial_code` |
| dout | output | 1 | Serial data to the host |
| dout_en | output | 1 | Drive enable for `dout`; low means high impedance |
| trial_code | output | RES_BITS | Code currently under test by the comparator |
| result | output | RES_BITS | Converted value, valid after `conv_done` |
| pos_ch | output | 1 | Channel routed to the positive input (0 or 1) |
| neg_is_gnd | output | 1 | 1 when the negative input is ground (single-ended) |
| sample_active | output | 1 | High during the sample window |
| conv_done | output | 1 | One-clock pulse when bit 0 is decided |

## Verification
A wrong bit counter or a wrong frame state shows at the port within one serial clock. The null bit appears a clock early or late, or the drive enable rises at the wrong fall, and every later data bit then lands one position off. A mislatched routing bit shows on `pos_ch`/`neg_is_gnd` right after the repeat-bit clock and, through the comparator model, corrupts the result from bit 11 onward. A lost lock after reset shows as a driven data line in a frame that must stay silent.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
   typedef enum logic [2:0] {
      ST_LOCK,
      ST_HUNT,
      ST_CFG,
      ST_CONV,
      ST_LSBF,
      ST_ZERO
   } frame_st_e;
endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic din,
   output logic cs_n_q,
   output logic din_q,
   output logic rise,
   output logic fall
);
   logic [2:0] last_q;
   logic       sclk_d;

   // Reset value keeps select "low" so a block reset under low select stays locked.
   if (SYNC_STAGES <= 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last_q <= 3'b000;
         else        last_q <= {cs_n, sclk, din};
      end
   end else begin : g_chain
      logic [SYNC_STAGES-1:0][2:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2:0], {cs_n, sclk, din}};
      end
      assign last_q = chain_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= last_q[1];
   end

   assign cs_n_q = last_q[2];
   assign din_q  = last_q[0];
   assign rise   = last_q[1] & ~sclk_d;
   assign fall   = ~last_q[1] & sclk_d;
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
   parameter int RES_BITS = 12,
   localparam int IDX_W = $clog2(RES_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic [IDX_W-1:0]    idx,
   input  logic                cmp,
   output logic [RES_BITS-1:0] code
);
   logic [RES_BITS-1:0] sar_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sar_q <= '0;
      end else if (load) begin
         sar_q <= {1'b1, {(RES_BITS-1){1'b0}}};
      end else if (step) begin
         sar_q[idx] <= cmp;
         if (idx != '0) sar_q[idx - 1'b1] <= 1'b1;
      end
   end

   assign code = sar_q;

   // R5: a low decision lowers the code, a high decision never lowers it
   a_r5_low_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !cmp) |=> (sar_q < $past(sar_q)));
   a_r5_high_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && cmp) |=> (sar_q >= $past(sar_q)));
endmodule

// File: rtl/adc_frame_ctl.sv
module adc_frame_ctl
   import adc_ser_pkg::*;
#(
   parameter int RES_BITS = 12,
   localparam int IDX_W = $clog2(RES_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n_q,
   input  logic                din_q,
   input  logic                rise,
   input  logic                fall,
   input  logic                cmp_in,
   input  logic [RES_BITS-1:0] res_bits,
   output logic                dout,
   output logic                dout_en,
   output logic                sample_active,
   output logic                conv_done,
   output logic                pos_ch,
   output logic                neg_is_gnd,
   output logic                sar_load,
   output logic                sar_step,
   output logic [IDX_W-1:0]    sar_idx
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);

   frame_st_e        st_q;
   logic [1:0]       cfg_cnt_q;
   logic             repeat_q;
   logic [IDX_W-1:0] idx_q;

   assign sar_load = !cs_n_q && fall && (st_q == ST_CFG) && (cfg_cnt_q == 2'd3);
   assign sar_step = !cs_n_q && fall && (st_q == ST_CONV);
   assign sar_idx  = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_LOCK;
         cfg_cnt_q     <= '0;
         repeat_q      <= 1'b0;
         idx_q         <= '0;
         dout          <= 1'b0;
         dout_en       <= 1'b0;
         sample_active <= 1'b0;
         conv_done     <= 1'b0;
         pos_ch        <= 1'b0;
         neg_is_gnd    <= 1'b0;
      end else begin
         conv_done <= 1'b0;
         if (cs_n_q) begin
            st_q          <= ST_HUNT;
            cfg_cnt_q     <= '0;
            dout_en       <= 1'b0;
            dout          <= 1'b0;
            sample_active <= 1'b0;
         end else begin
            unique case (st_q)
               ST_LOCK: ;
               ST_HUNT: if (rise && din_q) begin
                  st_q      <= ST_CFG;
                  cfg_cnt_q <= '0;
               end
               ST_CFG: begin
                  if (rise && cfg_cnt_q != 2'd3) begin
                     cfg_cnt_q <= cfg_cnt_q + 2'd1;
                     case (cfg_cnt_q)
                        2'd0:    neg_is_gnd <= din_q;
                        2'd1: begin
                           pos_ch        <= din_q;
                           sample_active <= 1'b1;
                        end
                        default: repeat_q <= din_q;
                     endcase
                  end else if (fall && cfg_cnt_q == 2'd3) begin
                     sample_active <= 1'b0;
                     dout_en       <= 1'b1;
                     dout          <= 1'b0;
                     idx_q         <= TOP_IDX;
                     st_q          <= ST_CONV;
                  end
               end
               ST_CONV: if (fall) begin
                  dout <= cmp_in;
                  if (idx_q == '0) begin
                     conv_done <= 1'b1;
                     idx_q     <= IDX_W'(1);
                     st_q      <= repeat_q ? ST_LSBF : ST_ZERO;
                  end else begin
                     idx_q <= idx_q - 1'b1;
                  end
               end
               ST_LSBF: if (fall) begin
                  dout <= res_bits[idx_q];
                  if (idx_q == TOP_IDX) st_q <= ST_ZERO;
                  else                  idx_q <= idx_q + 1'b1;
               end
               ST_ZERO: if (fall) dout <= 1'b0;
               default: st_q <= ST_HUNT;
            endcase
         end
      end
   end

   // R9: a high select releases the data line on the next clock
   a_r9_cs_high_release: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |=> (!dout_en && !sample_active));
   // R3: the sample window never overlaps a driven data line
   a_r3_window_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      sample_active |-> !dout_en);
   // R4: the first driven bit is the low null bit
   a_r4_null_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_en) |-> !dout);
   // R6: completion is a single-clock pulse
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> !conv_done);
   // R10: while locked nothing is driven and no window opens
   a_r10_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOCK) |-> (!dout_en && !sample_active));
endmodule

// File: rtl/adc_serial_dev.sv
module adc_serial_dev #(
   parameter int RES_BITS    = 12,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(RES_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                sclk,
   input  logic                din,
   input  logic                cmp_in,
   output logic                dout,
   output logic                dout_en,
   output logic [RES_BITS-1:0] trial_code,
   output logic [RES_BITS-1:0] result,
   output logic                pos_ch,
   output logic                neg_is_gnd,
   output logic                sample_active,
   output logic                conv_done
);
   logic             cs_n_q, din_q, rise, fall;
   logic             sar_load, sar_step;
   logic [IDX_W-1:0] sar_idx;
   logic [RES_BITS-1:0] code;

   adc_in_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .cs_n_q(cs_n_q), .din_q(din_q), .rise(rise), .fall(fall)
   );

   adc_frame_ctl #(.RES_BITS(RES_BITS)) ctl_i (
      .clk(clk), .rst_n(rst_n), .cs_n_q(cs_n_q), .din_q(din_q),
      .rise(rise), .fall(fall), .cmp_in(cmp_in), .res_bits(code),
      .dout(dout), .dout_en(dout_en), .sample_active(sample_active),
      .conv_done(conv_done), .pos_ch(pos_ch), .neg_is_gnd(neg_is_gnd),
      .sar_load(sar_load), .sar_step(sar_step), .sar_idx(sar_idx)
   );

   adc_sar_reg #(.RES_BITS(RES_BITS)) sar_i (
      .clk(clk), .rst_n(rst_n), .load(sar_load), .step(sar_step),
      .idx(sar_idx), .cmp(cmp_in), .code(code)
   );

   assign trial_code = code;
   assign result     = code;
endmodule

// File: tb/adc_serial_dev_tb_top.sv
module adc_serial_dev_tb_top;
   localparam int H  = 6;
   localparam int NV = 6;
   localparam int V_LEAD [NV] = '{0, 7, 3, 1, 5, 0};
   localparam int V_SGL  [NV] = '{1, 1, 0, 0, 0, 1};
   localparam int V_ODD  [NV] = '{0, 1, 0, 1, 1, 0};
   localparam int V_RPT  [NV] = '{0, 1, 1, 0, 1, 1};
   localparam int V_A0   [NV] = '{'hA5C, 'h0F0, 'h800, 'h300, 'h001, 'h000};
   localparam int V_A1   [NV] = '{'h123, 'hFFF, 'h100, 'h200, 'h556, 'h7FF};
   localparam int V_NCLK [NV] = '{20, 30, 29, 18, 28, 27};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b0, sclk = 1'b0, din = 1'b0;
   logic cmp_in;
   logic dout, dout_en, pos_ch, neg_is_gnd, sample_active, conv_done;
   logic [11:0] trial_code, result;

   int checks = 0, fails = 0, done_cnt = 0;
   int ain0 = 0, ain1 = 0, pos_v, neg_v;
   bit finished = 0;

   always #4 clk = ~clk;

   adc_serial_dev dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .cmp_in(cmp_in), .dout(dout), .dout_en(dout_en), .trial_code(trial_code),
      .result(result), .pos_ch(pos_ch), .neg_is_gnd(neg_is_gnd),
      .sample_active(sample_active), .conv_done(conv_done)
   );

   // analog front end model: routed by the block's mux outputs
   always_comb begin
      pos_v  = pos_ch ? ain1 : ain0;
      neg_v  = neg_is_gnd ? 0 : (pos_ch ? ain0 : ain1);
      cmp_in = ((pos_v - neg_v) >= int'(trial_code));
   end

   always @(posedge clk) if (conv_done) done_cnt <= done_cnt + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (H) @(negedge clk);
   endtask

   task automatic frame(input int lead, input int sgl, input int odd, input int rpt,
                        input int a0, input int a1, input int nclk,
                        input bit mode11, input bit locked);
      int tgt, pv, nv, e_en, e_dq;
      ain0 = a0; ain1 = a1;
      pv  = odd ? a1 : a0;
      nv  = sgl ? 0 : (odd ? a0 : a1);
      tgt = (pv > nv) ? pv - nv : 0;
      sclk = mode11; half();
      done_cnt = 0;
      cs_n = 1'b0; half();
      if (mode11) begin sclk = 1'b0; half(); end
      for (int i = 0; i < lead; i++) begin
         din = 1'b0; sclk = 1'b1; half(); sclk = 1'b0; half();
         chk("R1 leading zero leaves line released", dout_en, 0);
      end
      for (int c = 0; c < nclk; c++) begin
         din = (c == 0) ? 1'b1 : (c == 1) ? sgl[0] : (c == 2) ? odd[0] :
               (c == 3) ? rpt[0] : c[0];
         sclk = 1'b1; half();
         chk("R3 window at rise", sample_active, (!locked && (c == 2 || c == 3)) ? 1 : 0);
         sclk = 1'b0; half();
         chk("R3 window after fall", sample_active, (!locked && c == 2) ? 1 : 0);
         e_en = (!locked && c >= 3) ? 1 : 0;
         if (locked || c <= 3)              e_dq = 0;
         else if (c <= 15)                  e_dq = (tgt >> (15 - c)) & 1;
         else if (rpt != 0 && c <= 26)      e_dq = (tgt >> (c - 15)) & 1;
         else                               e_dq = 0;
         if (locked) chk("R10 locked frame stays released", dout_en, 0);
         else        chk("R4 drive enable", dout_en, e_en);
         if (e_en != 0) begin
            if (c == 3)       chk("R4 null bit", dout, 0);
            else if (c <= 15) chk("R5 data bit msb first", dout, e_dq);
            else if (rpt != 0 && c <= 26) chk("R7 lsb-first repeat bit", dout, e_dq);
            else if (rpt != 0) chk("R7 zeros after repeat", dout, 0);
            else              chk("R8 zeros after b0", dout, 0);
         end
         if (!locked && c == 3) begin
            chk("R2 pos_ch latched", pos_ch, odd);
            chk("R2 neg_is_gnd latched", neg_is_gnd, sgl);
            chk("R5 first trial code", trial_code, 'h800);
         end
         if (!locked && c == 14) chk("R6 no done before b0", done_cnt, 0);
         if (!locked && c == 15) begin
            chk("R6 done after b0", done_cnt, 1);
            chk("R11 straight binary result", result, tgt);
         end
      end
      if (locked || nclk < 16) chk("R6 no done in short frame", done_cnt, 0);
      else                     chk("R6 single done pulse", done_cnt, 1);
      cs_n = 1'b1;
      if (mode11) sclk = 1'b1;
      half();
      chk("R9 select high releases line", dout_en, 0);
      chk("R9 select high closes window", sample_active, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk("reset dout_en", dout_en, 0);
      chk("reset sample_active", sample_active, 0);
      chk("reset conv_done", conv_done, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R10: select low out of reset, full command must be ignored
      frame(0, 1, 0, 1, 'h400, 'h400, 20, 1'b0, 1'b1);
      for (int v = 0; v < NV; v++)
         frame(V_LEAD[v], V_SGL[v], V_ODD[v], V_RPT[v], V_A0[v], V_A1[v],
               V_NCLK[v], 1'b0, 1'b0);
      // R9: abort mid-conversion, then a full frame must work
      frame(2, 1, 1, 0, 'h3C3, 'h5A5, 9, 1'b0, 1'b0);
      frame(0, 1, 1, 0, 'h3C3, 'h5A5, 18, 1'b0, 1'b0);
      // idle-high serial clock, differential, repeat on (R1, R7)
      frame(4, 0, 0, 1, 'hFFF, 'h000, 29, 1'b1, 1'b0);
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule